// File: doc/BRIEF.md
# Highest-Supply Selection Arbiter

This block decides which of five monitored supply rails should power the device. Each cycle it receives a digitized voltage code for four low-voltage rails and one high-voltage rail. All five codes share one LSB weight. From these it produces a registered one-hot select and a valid flag. Only rails at or above a minimum operating code may be chosen. Among those, the highest is preferred.

The choice is sticky. Once a rail holds the select, a rival takes over only when its code is more than a fixed margin above the holder's code. That margin represents roughly 100 mV. If the holder falls below the minimum code, the block drops it at the next clock and picks the highest rail that is still qualified.

If no rail qualifies, valid falls and the select keeps its last value. A first choice, or a fresh choice after a dropout, has no holder. In that case the block picks the highest qualified code. Equal codes go to the lowest slot number, so the low-voltage rails in slots 0 to 3 come before the high-voltage rail in slot 4.

Top module: `supply_arbiter`

## Requirements
- R1: Reset (active-low, asynchronous) forces `sel_o` to 00000 and `valid_o` to 0 at once, so that no rail is held.
- R2: Whenever `valid_o` is 1, `sel_o` has exactly one bit set. Bit i selects the rail whose code sits at `sup_code_i[i*12 +: 12]`.
- R3: With no qualified holder, the block selects the rail with the highest qualified code. Equal codes resolve to the lowest slot index, so slots 0 to 3 (low-voltage) come before slot 4 (high-voltage).
- R4: A qualified holder keeps the select while no other qualified rail exceeds it by more than MARGIN_CODE (25) codes. A gap of exactly 25 keeps the holder.
- R5: When another qualified rail exceeds a qualified holder by more than MARGIN_CODE codes, the highest such rail takes the select at the next clock. This holds even when the holder code plus the margin exceeds 4095.
- R6: When the holder's code falls below MIN_CODE while another rail qualifies, the holder is replaced at the next clock by the highest qualified rail, following the R3 rules.
- R7: When no rail is at or above MIN_CODE, `valid_o` becomes 0 at the next clock and `sel_o` keeps its previous value.
- R8: A rail qualifies when its code is at or above MIN_CODE (750). The bound is inclusive. A selected rail was always qualified in the cycle it was chosen.
- R9: Outputs follow the codes with one clock of latency. A code change made between edges is not visible on `sel_o` until after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_code_i | input | 60 | Five 12-bit rail codes; slot i at bits i*12 +: 12, slots 0-3 low-voltage, slot 4 high-voltage |
| sel_o | output | 5 | One-hot rail select |
| valid_o | output | 1 | At least one rail qualified in the previous cycle |

## Verification
The bench probes the margin boundary from both sides: gaps of 20 and exactly 25 must hold the select, and a gap of 26 must move it. An arbiter using `>=` would move one step early, and a plain maximum selector would move at the first gap of 20. The minimum bound is tested with codes of 749 and 750. An off-by-one threshold would either pick a rail at 749 or lose the valid flag at 750. Equal codes are checked between a low-voltage slot and the high-voltage slot, where a reversed scan would pick the wrong rail. A holder at 4095 facing a rival at 4095 must keep the select. A design that adds the margin without a carry bit would wrap and hand the select over.

// File: rtl/sarb_pkg.sv
package sarb_pkg;

   // Default geometry of the arbiter
   localparam int unsigned SARB_NUM_RAILS = 5;
   localparam int unsigned SARB_CODE_W    = 12;

   // Outcome of one arbitration cycle
   typedef enum logic [1:0] {
      DEC_NONE  = 2'd0,   // nothing qualifies: drop valid, keep select
      DEC_HOLD  = 2'd1,   // holder keeps the select
      DEC_TAKE  = 2'd2,   // rival beats holder by more than the margin
      DEC_FRESH = 2'd3    // no qualified holder: pick the highest
   } sarb_dec_e;

endpackage

// File: rtl/sarb_qualify.sv
module sarb_qualify #(
   parameter int unsigned NUM      = 5,
   parameter int unsigned W        = 12,
   parameter int unsigned MIN_CODE = 750
) (
   input  logic [NUM*W-1:0] codes_i,
   output logic [NUM-1:0]   elig_o,
   output logic             any_o
);

   localparam logic [W-1:0] MIN_V = W'(MIN_CODE);

   for (genvar g = 0; g < NUM; g++) begin : g_rail
      assign elig_o[g] = (codes_i[g*W +: W] >= MIN_V);
   end

   assign any_o = |elig_o;

endmodule

// File: rtl/sarb_pick.sv
module sarb_pick #(
   parameter int unsigned NUM = 5,
   parameter int unsigned W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM-1:0]   mask_i,
   input  logic [NUM*W-1:0] codes_i,
   output logic             found_o,
   output logic [NUM-1:0]   onehot_o,
   output logic [W-1:0]     code_o
);

   // Linear scan; strict compare keeps the lowest index on equal codes
   always_comb begin
      found_o  = 1'b0;
      onehot_o = '0;
      code_o   = '0;
      for (int i = 0; i < NUM; i++) begin
         if (mask_i[i] && (!found_o || (codes_i[i*W +: W] > code_o))) begin
            found_o     = 1'b1;
            onehot_o    = '0;
            onehot_o[i] = 1'b1;
            code_o      = codes_i[i*W +: W];
         end
      end
   end

   // R3: the winner is one member of the candidate set
   p_pick_in_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |-> (($countones(onehot_o) == 1) && ((onehot_o & ~mask_i) == '0)));

   // R3: no candidate beats the reported winner
   for (genvar g = 0; g < NUM; g++) begin : g_max_chk
      p_pick_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
         mask_i[g] |-> (found_o && (codes_i[g*W +: W] <= code_o)));
   end

endmodule

// File: rtl/sarb_decide.sv
module sarb_decide
   import sarb_pkg::*;
#(
   parameter int unsigned NUM         = 5,
   parameter int unsigned W           = 12,
   parameter int unsigned MARGIN_CODE = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM*W-1:0] codes_i,
   input  logic [NUM-1:0]   elig_i,
   input  logic             any_i,
   input  logic [NUM-1:0]   sel_q_i,
   input  logic             valid_q_i,
   input  logic             chal_found_i,
   input  logic [NUM-1:0]   chal_oh_i,
   input  logic [W-1:0]     chal_code_i,
   input  logic [NUM-1:0]   fresh_oh_i,
   output logic [NUM-1:0]   sel_d_o,
   output logic             valid_d_o
);

   localparam int unsigned XW   = W + 1;
   localparam logic [XW-1:0] MARG = XW'(MARGIN_CODE);

   logic [W-1:0]  inc_code;
   logic          inc_elig;
   logic [XW-1:0] inc_bar;
   logic          gap_ok;
   sarb_dec_e     dec;

   // Code of the current holder, selected by the one-hot register
   always_comb begin
      inc_code = '0;
      for (int i = 0; i < NUM; i++) begin
         if (sel_q_i[i]) inc_code = inc_code | codes_i[i*W +: W];
      end
   end

   assign inc_elig = valid_q_i && |(sel_q_i & elig_i);
   // One extra bit so a holder near full scale cannot wrap the bar
   assign inc_bar  = {1'b0, inc_code} + MARG;
   assign gap_ok   = chal_found_i && ({1'b0, chal_code_i} > inc_bar);

   always_comb begin
      if (!any_i)        dec = DEC_NONE;
      else if (inc_elig) dec = gap_ok ? DEC_TAKE : DEC_HOLD;
      else               dec = DEC_FRESH;
   end

   always_comb begin
      unique case (dec)
         DEC_NONE:  sel_d_o = sel_q_i;
         DEC_HOLD:  sel_d_o = sel_q_i;
         DEC_TAKE:  sel_d_o = chal_oh_i;
         DEC_FRESH: sel_d_o = fresh_oh_i;
         default:   sel_d_o = sel_q_i;
      endcase
      valid_d_o = (dec != DEC_NONE);
   end

   // R4: a qualified holder without a rival past the margin is kept
   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q_i && |(sel_q_i & elig_i) && !(chal_found_i &&
         ({1'b0, chal_code_i} > ({1'b0, inc_code} + MARG)))) |-> (sel_d_o == sel_q_i));

   // R5: a qualified holder only moves to a rival past the margin
   p_takeover_margin_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q_i && |(sel_q_i & elig_i) && (sel_d_o != sel_q_i)) |->
         ((sel_d_o == chal_oh_i) && ({1'b0, chal_code_i} > inc_bar)));

endmodule

// File: rtl/supply_arbiter.sv
module supply_arbiter
   import sarb_pkg::*;
#(
   parameter int unsigned NUM         = SARB_NUM_RAILS,
   parameter int unsigned W           = SARB_CODE_W,
   parameter int unsigned MIN_CODE    = 750,
   parameter int unsigned MARGIN_CODE = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM*W-1:0] sup_code_i,
   output logic [NUM-1:0]   sel_o,
   output logic             valid_o
);

   localparam longint unsigned FULL = (64'd1 << W);

   initial begin : elab_chk
      a_num_r2: assert (NUM >= 2) else $error("NUM must be at least 2");
      a_width_r8: assert (W >= 2 && W <= 31) else $error("W out of range");
      a_min_r8: assert (MIN_CODE < FULL) else $error("MIN_CODE exceeds code range");
      a_marg_r4: assert (MARGIN_CODE < FULL) else $error("MARGIN_CODE exceeds code range");
   end

   logic [NUM-1:0] elig;
   logic           any_elig;
   logic [NUM-1:0] sel_q;
   logic           valid_q;
   logic [NUM-1:0] chal_mask;
   logic           chal_found, fresh_found;
   logic [NUM-1:0] chal_oh, fresh_oh;
   logic [W-1:0]   chal_code, fresh_code;
   logic [NUM-1:0] sel_d;
   logic           valid_d;

   sarb_qualify #(.NUM(NUM), .W(W), .MIN_CODE(MIN_CODE)) u_qual (
      .codes_i (sup_code_i),
      .elig_o  (elig),
      .any_o   (any_elig)
   );

   // A rival is any qualified rail other than the holder
   assign chal_mask = elig & ~(valid_q ? sel_q : '0);

   sarb_pick #(.NUM(NUM), .W(W)) u_pick_chal (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_i   (chal_mask),
      .codes_i  (sup_code_i),
      .found_o  (chal_found),
      .onehot_o (chal_oh),
      .code_o   (chal_code)
   );

   sarb_pick #(.NUM(NUM), .W(W)) u_pick_fresh (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_i   (elig),
      .codes_i  (sup_code_i),
      .found_o  (fresh_found),
      .onehot_o (fresh_oh),
      .code_o   (fresh_code)
   );

   sarb_decide #(.NUM(NUM), .W(W), .MARGIN_CODE(MARGIN_CODE)) u_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .codes_i      (sup_code_i),
      .elig_i       (elig),
      .any_i        (any_elig),
      .sel_q_i      (sel_q),
      .valid_q_i    (valid_q),
      .chal_found_i (chal_found),
      .chal_oh_i    (chal_oh),
      .chal_code_i  (chal_code),
      .fresh_oh_i   (fresh_oh),
      .sel_d_o      (sel_d),
      .valid_d_o    (valid_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         sel_q   <= sel_d;
         valid_q <= valid_d;
      end
   end

   assign sel_o   = sel_q;
   assign valid_o = valid_q;

   // R2: a valid select is one-hot
   p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ($countones(sel_o) == 1));

   // R7: nothing qualified -> valid drops, select frozen
   p_none_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !any_elig |=> (!valid_o && $stable(sel_o)));

   // R8: the selected rail qualified in the cycle it was registered
   p_sel_eligible_r8: assert property (@(posedge clk) disable iff (!rst_n)
      any_elig |=> (valid_o && ((sel_o & $past(elig)) != '0)));

   // R3: a fresh pick always finds a winner when something qualifies
   p_fresh_found_r3: assert property (@(posedge clk) disable iff (!rst_n)
      any_elig |-> (fresh_found && (fresh_code >= W'(MIN_CODE))));

endmodule

// File: tb/supply_arbiter_test.sv
module supply_arbiter_test;

   localparam int unsigned NUM = 5;
   localparam int unsigned W   = 12;
   localparam int NV = 14;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NUM*W-1:0] sup_code = '0;
   logic [NUM-1:0]   sel;
   logic             valid;

   int n_total = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   supply_arbiter uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sup_code_i (sup_code),
      .sel_o      (sel),
      .valid_o    (valid)
   );

   always #4 clk = ~clk;   // 125 MHz

   // {slot4, slot3, slot2, slot1, slot0, exp_valid, exp_sel}; MIN 750, margin 25
   localparam logic [65:0] VECS [0:NV-1] = '{
      {12'd0,    12'd0,    12'd0,    12'd0,    12'd0,    1'b0, 5'b00000},
      {12'd850,  12'd700,  12'd900,  12'd900,  12'd800,  1'b1, 5'b00010},
      {12'd850,  12'd700,  12'd920,  12'd900,  12'd800,  1'b1, 5'b00010},
      {12'd850,  12'd700,  12'd925,  12'd900,  12'd800,  1'b1, 5'b00010},
      {12'd850,  12'd700,  12'd926,  12'd900,  12'd800,  1'b1, 5'b00100},
      {12'd950,  12'd700,  12'd926,  12'd900,  12'd800,  1'b1, 5'b00100},
      {12'd950,  12'd700,  12'd700,  12'd900,  12'd800,  1'b1, 5'b10000},
      {12'd749,  12'd760,  12'd760,  12'd760,  12'd760,  1'b1, 5'b00001},
      {12'd749,  12'd749,  12'd749,  12'd749,  12'd749,  1'b0, 5'b00001},
      {12'd750,  12'd749,  12'd749,  12'd749,  12'd750,  1'b1, 5'b00001},
      {12'd776,  12'd749,  12'd749,  12'd749,  12'd750,  1'b1, 5'b10000},
      {12'd776,  12'd0,    12'd0,    12'd0,    12'd4095, 1'b1, 5'b00001},
      {12'd4095, 12'd0,    12'd0,    12'd0,    12'd4095, 1'b1, 5'b00001},
      {12'd0,    12'd3000, 12'd0,    12'd0,    12'd0,    1'b1, 5'b01000}
   };

   localparam string TAGS [0:NV-1] = '{
      "R7 none qualified from reset",
      "R3 fresh pick, equal codes to lowest slot",
      "R4 rival 20 above holder",
      "R4 rival exactly margin above holder",
      "R5 rival margin+1 above holder",
      "R4 high-voltage rival 24 above holder",
      "R6 holder below minimum",
      "R6 reselect with LV tie",
      "R7 all at 749",
      "R8 750 qualifies, LV wins tie over HV",
      "R5 HV takes over by 26",
      "R5 full-scale rival",
      "R5 holder at 4095, no wrap",
      "R6 holder lost, single rail left"
   };

   task automatic chk(input string tag, input logic [NUM-1:0] e_sel, input logic e_v);
      n_total++;
      if (sel !== e_sel || valid !== e_v) begin
         n_fail++;
         $display("FAIL %s: sel=%b valid=%b expected sel=%b valid=%b",
                  tag, sel, valid, e_sel, e_v);
      end
   endtask

   initial begin : watchdog
      #(8 * 20000);
      if (!finished) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk("R1 reset state", 5'b00000, 1'b0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         sup_code = VECS[k][65:6];
         @(negedge clk);
         chk(TAGS[k], VECS[k][4:0], VECS[k][5]);
         if (VECS[k][5]) begin
            n_total++;
            if ($countones(sel) != 1) begin
               n_fail++;
               $display("FAIL R2 one-hot: ones=%0d expected 1", $countones(sel));
            end
         end
      end

      // R9: change appears only after the next rising edge
      sup_code = {12'd3000, 12'd0, 12'd0, 12'd0, 12'd0};
      #2;
      chk("R9 before edge, old select", 5'b01000, 1'b1);
      @(negedge clk);
      chk("R9 after edge, new select", 5'b10000, 1'b1);

      // R1: asynchronous reset mid-run
      rst_n = 1'b0;
      #1;
      chk("R1 async reset clears outputs", 5'b00000, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 first pick after reset", 5'b10000, 1'b1);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule